// File: doc/BRIEF.md
# Non-Posted Request Credit Gate

This block sits between a completer's receive path and the logic that consumes incoming request packets. Each packet arrives as one or more beats on a valid/ready stream and carries a class tag: posted (a write) or non-posted (a read). The gate stores the packets in two internal queues, one for each class. It forwards whole packets on an output stream that has its own valid/ready/last handshake.

Non-posted packets may leave only while a credit counter is above zero. The downstream consumer adds credits through a 2-bit grant input. The gate spends one credit each time it commits to a non-posted packet. When no credit is left, non-posted packets wait, and posted packets that arrived after them are delivered first. When credit is available, packets leave in arrival order across both classes.

A three-state machine controls the output:
- `ST_IDLE`: nothing is being sent. The gate picks the next packet here.
- `ST_SEND_P`: a posted packet is being sent.
- `ST_SEND_NP`: a non-posted packet is being sent.

It has four transitions:
- `ST_IDLE`→`ST_SEND_P` (take posted): the posted head is older, or the non-posted side is blocked or empty.
- `ST_IDLE`→`ST_SEND_NP` (commit read): the non-posted head may go. This transition spends one credit.
- `ST_SEND_P`→`ST_IDLE` (posted done): the last beat of the posted packet is accepted.
- `ST_SEND_NP`→`ST_IDLE` (read done): the last beat of the non-posted packet is accepted.

Top module: `np_credit_gate`

## Requirements
- R1: After reset, `credit_count` is 0, `credit_ovf` is 0, `out_valid` is 0, and both queues are empty, so `in_ready` is 1 for either class.
- R2: In each cycle, `credit_grant` adds credit that is visible on `credit_count` one clock later. The encoding is 2'b00 = none, 2'b01 = +1, 2'b10 = +2 and 2'b11 = +2.
- R3: `credit_count` never exceeds 32. When the next value would exceed 32, it saturates at 32 and `credit_ovf` is high for exactly that one update cycle.
- R4: While `credit_count` is 0, no non-posted packet is started on the output.
- R5: Committing to a non-posted packet (`ST_IDLE`→`ST_SEND_NP`) lowers the count by one. A grant in the same cycle is added in the same update, so the change is the net of the two.
- R6: While non-posted packets are blocked for lack of credit, posted packets that arrived after them are delivered.
- R7: Packets of the same class leave in the order they arrived.
- R8: When credit is available, the older of the two queue heads is sent first, so arrival order across the classes is kept.
- R9: Once the first beat of a packet is shown, that packet's beats follow one another until `out_last` with no beat of another packet in between. A shown beat holds its data and last flag until it is accepted.
- R10: `in_ready` is low when the queue for the incoming beat's class is full. The class is `in_np` on the first beat of a packet and the latched class on later beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | DATA_W | Input beat payload |
| in_last | input | 1 | Last beat of the input packet |
| in_np | input | 1 | Class of the packet on its first beat: 1 non-posted, 0 posted |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | DATA_W | Output beat payload |
| out_last | output | 1 | Last beat of the output packet |
| out_np | output | 1 | Class of the packet being sent |
| credit_grant | input | 2 | Credit added this cycle (00 none, 01 one, 10/11 two) |
| credit_count | output | CNT_W | Available non-posted credit, 0 to CREDIT_MAX |
| credit_ovf | output | 1 | One-cycle pulse when a grant was clipped at the maximum |

## Verification
The bench first runs a table of grant codes that includes the 2'b11 alias, then drives the counter to its ceiling. A counter that wrapped, or that treated 2'b11 as 3, would show the wrong `credit_count`; a flag that stuck or fired early would show on `credit_ovf`. With the count at zero, the bench queues a read ahead of writes and expects the writes to arrive alone; a gate without the credit check would send the read, and one without bypass would stall. With credit present, it queues a read ahead of a write behind a stalled posted packet and expects the read first, which a gate that always favoured writes would get wrong. Finally it fills the read queue to check backpressure per class, then drains it to confirm read order and that the net count returns to zero.

// File: rtl/np_gate_pkg.sv
package np_gate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SEND_P  = 2'd1,
        ST_SEND_NP = 2'd2
    } gate_state_e;

    // 00 -> 0, 01 -> 1, 10 and 11 -> 2
    function automatic logic [1:0] grant_amount(input logic [1:0] code);
        unique case (code)
            2'b00:   grant_amount = 2'd0;
            2'b01:   grant_amount = 2'd1;
            default: grant_amount = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/gate_fifo.sv
module gate_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_q, rd_q;

    assign empty = (wr_q == rd_q);
    assign full  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
    assign rdata = mem[rd_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_q[AW-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + 1'b1;
            if (pop)  rd_q <= rd_q + 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R9

endmodule

// File: rtl/np_credit_counter.sv
module np_credit_counter
    import np_gate_pkg::*;
#(
    parameter int CREDIT_MAX = 32,
    localparam int CNT_W     = $clog2(CREDIT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       grant,
    input  logic             take,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             has_credit
);
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum = {1'b0, cnt_q}
            + {{(CNT_W-1){1'b0}}, grant_amount(grant)}
            - {{CNT_W{1'b0}}, take};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (sum > (CNT_W+1)'(CREDIT_MAX)) begin
            cnt_q <= CNT_W'(CREDIT_MAX);
            ovf_q <= 1'b1;
        end else begin
            cnt_q <= sum[CNT_W-1:0];
            ovf_q <= 1'b0;
        end
    end

    assign count      = cnt_q;
    assign ovf        = ovf_q;
    assign has_credit = (cnt_q != '0);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CREDIT_MAX)); // R3
    AST_OVF_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (cnt_q == CNT_W'(CREDIT_MAX))); // R3
    AST_TAKE_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (cnt_q != '0)); // R4

endmodule

// File: rtl/np_credit_gate.sv
module np_credit_gate
    import np_gate_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int P_DEPTH    = 8,
    parameter int N_DEPTH    = 8,
    parameter int CREDIT_MAX = 32,
    localparam int CNT_W     = $clog2(CREDIT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_np,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_np,
    input  logic [1:0]        credit_grant,
    output logic [CNT_W-1:0]  credit_count,
    output logic              credit_ovf
);
    // Arrival stamp wide enough to order every packet that can be queued
    localparam int STAMP_W = $clog2(P_DEPTH + N_DEPTH) + 1;
    localparam int ENT_W   = STAMP_W + 1 + DATA_W;

    gate_state_e state_q, state_d;

    logic               first_q, cls_q, in_cls;
    logic [STAMP_W-1:0] stamp_q;
    logic               in_fire;
    logic [ENT_W-1:0]   in_entry;

    logic               p_push, n_push, p_pop, n_pop;
    logic               p_empty, n_empty, p_full, n_full;
    logic [ENT_W-1:0]   p_head, n_head;
    logic [STAMP_W-1:0] p_stamp, n_stamp, age_diff;
    logic               has_credit, np_older, pick_np, pick_p, take;
    logic               sel_empty, sel_last;

    // ---------------- input side ----------------
    assign in_cls   = first_q ? in_np : cls_q;
    assign in_ready = in_cls ? !n_full : !p_full;
    assign in_fire  = in_valid && in_ready;
    assign in_entry = {stamp_q, in_last, in_data};
    assign p_push   = in_fire && !in_cls;
    assign n_push   = in_fire &&  in_cls;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
            cls_q   <= 1'b0;
            stamp_q <= '0;
        end else if (in_fire) begin
            cls_q   <= in_cls;
            first_q <= in_last;
            if (in_last) stamp_q <= stamp_q + 1'b1;
        end
    end

    gate_fifo #(.W(ENT_W), .DEPTH(P_DEPTH)) p_fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (p_push),
        .wdata (in_entry),
        .pop   (p_pop),
        .rdata (p_head),
        .empty (p_empty),
        .full  (p_full)
    );

    gate_fifo #(.W(ENT_W), .DEPTH(N_DEPTH)) n_fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (n_push),
        .wdata (in_entry),
        .pop   (n_pop),
        .rdata (n_head),
        .empty (n_empty),
        .full  (n_full)
    );

    np_credit_counter #(.CREDIT_MAX(CREDIT_MAX)) credit_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant      (credit_grant),
        .take       (take),
        .count      (credit_count),
        .ovf        (credit_ovf),
        .has_credit (has_credit)
    );

    // ---------------- packet choice ----------------
    assign p_stamp  = p_head[ENT_W-1 -: STAMP_W];
    assign n_stamp  = n_head[ENT_W-1 -: STAMP_W];
    assign age_diff = p_stamp - n_stamp;
    assign np_older = !age_diff[STAMP_W-1];
    assign pick_np  = !n_empty && has_credit && (p_empty || np_older);
    assign pick_p   = !p_empty && !pick_np;
    assign take     = (state_q == ST_IDLE) && pick_np;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_np)     state_d = ST_SEND_NP;
                else if (pick_p) state_d = ST_SEND_P;
            end
            ST_SEND_P: begin
                if (p_pop && p_head[DATA_W]) state_d = ST_IDLE;
            end
            ST_SEND_NP: begin
                if (n_pop && n_head[DATA_W]) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        out_np    = 1'b0;
        p_pop     = 1'b0;
        n_pop     = 1'b0;
        sel_empty = 1'b1;
        sel_last  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_SEND_P: begin
                sel_empty = p_empty;
                sel_last  = p_head[DATA_W];
                out_valid = !p_empty;
                out_data  = p_head[DATA_W-1:0];
                out_last  = sel_last;
                p_pop     = !p_empty && out_ready;
            end
            ST_SEND_NP: begin
                sel_empty = n_empty;
                sel_last  = n_head[DATA_W];
                out_valid = !n_empty;
                out_data  = n_head[DATA_W-1:0];
                out_last  = sel_last;
                out_np    = 1'b1;
                n_pop     = !n_empty && out_ready;
            end
            default: begin
            end
        endcase
    end

    AST_NP_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && state_d == ST_SEND_NP) |-> (credit_count != '0)); // R4
    AST_COMMIT_TAKES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && state_d == ST_SEND_NP && credit_grant == 2'b00)
        |=> (credit_count == $past(credit_count) - 1'b1)); // R5
    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R9
    AST_NO_SWITCH_MID_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && out_last)) |=> (state_q == $past(state_q))); // R9
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !out_valid); // R9
    AST_SEL_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!sel_empty && out_last == sel_last)); // R9

endmodule

// File: tb/np_credit_gate_tb_top.sv
module np_credit_gate_tb_top;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_ready, in_last, in_np;
    logic [DW-1:0] in_data;
    logic          out_valid, out_ready, out_last, out_np;
    logic [DW-1:0] out_data;
    logic [1:0]    credit_grant;
    logic [5:0]    credit_count;
    logic          credit_ovf;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk; // 50 MHz

    np_credit_gate dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .in_last      (in_last),
        .in_np        (in_np),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_data     (out_data),
        .out_last     (out_last),
        .out_np       (out_np),
        .credit_grant (credit_grant),
        .credit_count (credit_count),
        .credit_ovf   (credit_ovf)
    );

    // output log, appended on every accepted beat
    logic [DW-1:0] log_d  [64];
    logic          log_np [64];
    logic          log_l  [64];
    int            log_n = 0;

    always @(posedge clk) begin
        if (rst_n && out_valid && out_ready && log_n < 64) begin
            log_d[log_n]  <= out_data;
            log_np[log_n] <= out_np;
            log_l[log_n]  <= out_last;
            log_n         <= log_n + 1;
        end
    end

    // {grant code, expected count, expected overflow}, from count 0
    localparam logic [8:0] GVEC [8] = '{
        {2'b01, 6'd1,  1'b0},
        {2'b10, 6'd3,  1'b0},
        {2'b11, 6'd5,  1'b0},
        {2'b00, 6'd5,  1'b0},
        {2'b10, 6'd7,  1'b0},
        {2'b01, 6'd8,  1'b0},
        {2'b00, 6'd8,  1'b0},
        {2'b11, 6'd10, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_np = 1'b0;
        in_data = '0; out_ready = 1'b0; credit_grant = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic grant_step(input logic [1:0] g);
        @(negedge clk);
        credit_grant = g;
        @(negedge clk);
        credit_grant = 2'b00;
    endtask

    task automatic push_beat(input logic np, input logic [DW-1:0] d, input logic last);
        @(negedge clk);
        in_valid = 1'b1; in_np = np; in_data = d; in_last = last;
        @(posedge clk);
        while (!in_ready) @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic push_pkt(input logic np, input logic [DW-1:0] base, input int len);
        for (int i = 0; i < len; i++) push_beat(np, base + DW'(i), (i == len - 1));
    endtask

    task automatic chk_beat(input string req, input int idx, input logic [DW-1:0] d,
                            input logic np, input logic last);
        chk(req, log_d[idx], d);
        chk(req, {31'd0, log_np[idx]}, {31'd0, np});
        chk(req, {31'd0, log_l[idx]}, {31'd0, last});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;

        // ---- R1 reset state ----
        do_reset();
        chk("R1 count", credit_count, 0);
        chk("R1 ovf", credit_ovf, 0);
        chk("R1 out_valid", out_valid, 0);
        in_np = 1'b1;
        #1 chk("R1 ready np", in_ready, 1);
        in_np = 1'b0;
        #1 chk("R1 ready p", in_ready, 1);

        // ---- R2 grant table ----
        for (int i = 0; i < 8; i++) begin
            grant_step(GVEC[i][8:7]);
            chk("R2 count", credit_count, GVEC[i][6:1]);
            chk("R3 ovf", credit_ovf, GVEC[i][0]);
        end

        // ---- R3 saturation: 10 + 11*2 = 32 exactly, then clip ----
        for (int i = 0; i < 11; i++) grant_step(2'b11);
        chk("R3 at max", credit_count, 32);
        chk("R3 no ovf at exact max", credit_ovf, 0);
        grant_step(2'b01);
        chk("R3 saturated", credit_count, 32);
        chk("R3 ovf pulse", credit_ovf, 1);
        grant_step(2'b00);
        chk("R3 ovf cleared", credit_ovf, 0);

        // ---- R4 R6 R7: zero credit, posted bypasses a queued read ----
        do_reset();
        out_ready = 1'b1;
        base = log_n;
        push_pkt(1'b1, 32'h100, 2);
        push_pkt(1'b0, 32'h200, 1);
        push_pkt(1'b0, 32'h300, 3);
        repeat (10) @(negedge clk);
        chk("R6 bypass count", log_n - base, 4);
        chk_beat("R6 first posted", base + 0, 32'h200, 1'b0, 1'b1);
        chk_beat("R7 posted order", base + 1, 32'h300, 1'b0, 1'b0);
        chk_beat("R7 posted order", base + 3, 32'h302, 1'b0, 1'b1);
        chk("R4 read held", out_valid, 0);
        chk("R4 count zero", credit_count, 0);
        grant_step(2'b01);
        repeat (6) @(negedge clk);
        chk("R4 read after grant", log_n - base, 6);
        chk_beat("R9 read beat0", base + 4, 32'h100, 1'b1, 1'b0);
        chk_beat("R9 read beat1", base + 5, 32'h101, 1'b1, 1'b1);
        chk("R5 net count", credit_count, 0);

        // ---- R8 R5: with credit, an older read goes before a newer write ----
        do_reset();
        grant_step(2'b10);
        chk("R2 start credit", credit_count, 2);
        base = log_n;
        push_pkt(1'b0, 32'h400, 4);
        push_pkt(1'b1, 32'h500, 1);
        push_pkt(1'b0, 32'h600, 1);
        repeat (3) @(negedge clk);
        chk("R9 beat shown under stall", out_data, 32'h400);
        @(negedge clk);
        out_ready = 1'b1;
        repeat (12) @(negedge clk);
        chk("R8 beats", log_n - base, 6);
        chk_beat("R9 posted contiguous", base + 3, 32'h403, 1'b0, 1'b1);
        chk_beat("R8 read before newer write", base + 4, 32'h500, 1'b1, 1'b1);
        chk_beat("R8 newer write last", base + 5, 32'h600, 1'b0, 1'b1);
        chk("R5 one credit spent", credit_count, 1);

        // ---- R10 R7: fill the read queue, class-specific backpressure ----
        do_reset();
        for (int i = 0; i < 8; i++) push_beat(1'b1, 32'h700 + DW'(i), 1'b1);
        @(negedge clk);
        in_valid = 1'b1; in_np = 1'b1; in_last = 1'b1; in_data = 32'hDEAD;
        #1 chk("R10 read queue full", in_ready, 0);
        in_np = 1'b0;
        #1 chk("R10 posted still open", in_ready, 1);
        in_valid = 1'b0;
        chk("R4 no read without credit", out_valid, 0);
        base = log_n;
        out_ready = 1'b1;
        for (int i = 0; i < 4; i++) grant_step(2'b10);
        repeat (20) @(negedge clk);
        chk("R7 drained", log_n - base, 8);
        for (int i = 0; i < 8; i++)
            chk_beat("R7 read order", base + i, 32'h700 + DW'(i), 1'b1, 1'b1);
        chk("R5 net after drain", credit_count, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule